// File: doc/BRIEF.md
# Copy-Row Activation Controller

This block sits in a DRAM memory controller in front of one bank and decides how each row activation is issued. Every subarray of the bank holds ordinary rows plus a small pool of spare duplicate rows, reached through a decoder of their own. The controller keeps a tag table per subarray recording which ordinary row, if any, each spare row currently mirrors. A request for a row that is not mirrored produces an ordinary activation followed, a fixed few cycles later, by an activation of a spare row in the same subarray, so restoration through the shared sense amplifiers writes the data into both rows. A request for a row that is already mirrored produces a joint activation of both rows, which is allowed a shorter activate-to-read delay.

The same pool of spare rows also holds permanent replacements for rows with short retention. A request flagged as a pin installs its row as such a replacement, or converts an existing mirror into one. Pinned entries are never evicted. Ordinary mirrors are replaced in least-recently-used order and need no write-back, because the ordinary row always holds current data. When every spare row of a subarray is pinned, misses fall back to a plain activation with no allocation.

Requests are accepted one at a time. After a command is issued the controller counts the activate-to-read delay, raises a column-ready pulse when it expires, and refuses new requests until then.

Top module: `copyrow_act_ctrl`

## Requirements
- R1: After reset, req_ready is 1 and cmd_valid, copy_act and col_ok are 0; all spare rows are free.
- R2: A request for a row with no mirror in a subarray that has a free spare row issues cmd_kind 2 (fill) with cmd_copy set to the lowest-numbered free spare row. Kind codes are 1 plain, 2 fill, 3 dual; 0 never appears with cmd_valid.
- R3: A request for a row already mirrored in its subarray issues cmd_kind 3 (dual) with cmd_copy set to the spare row that holds it.
- R4: copy_act pulses for one cycle exactly T_GAP cycles after the cmd_valid cycle of a fill command, and never after a plain or dual command.
- R5: col_ok pulses exactly T_FAST cycles after the cmd_valid cycle of a dual command and exactly T_FULL cycles after a plain or fill command.
- R6: req_ready is 0 from the cmd_valid cycle until the col_ok cycle; a request presented while req_ready is 0 is ignored and leaves no trace in the table.
- R7: A miss in a subarray whose spare rows are all valid replaces the least recently used non-pinned entry, where fills and hits both count as uses.
- R8: A request with req_pin set that misses allocates a spare row like a fill and marks it pinned; a pinned entry is never chosen as a victim and keeps answering with dual.
- R9: When every spare row of a subarray is pinned, a miss issues cmd_kind 1 (plain), allocates nothing and issues no copy activation.
- R10: A request with req_pin set that hits an existing mirror issues dual on that spare row and pins it.
- R11: Each subarray has its own table; a row mirrored in one subarray is a miss in another.
- R12: cmd_valid is a one-cycle pulse in the cycle after acceptance, with cmd_sa and cmd_row equal to the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Activation request present |
| req_sa | input | SA_W | Subarray of the requested row |
| req_row | input | ROW_W | Ordinary row index within the subarray |
| req_pin | input | 1 | Install this row as a permanent replacement |
| req_ready | output | 1 | Request can be accepted this cycle |
| cmd_valid | output | 1 | Activation command issued this cycle |
| cmd_kind | output | 2 | 1 plain, 2 fill, 3 dual |
| cmd_sa | output | SA_W | Subarray of the command |
| cmd_row | output | ROW_W | Ordinary row address |
| cmd_copy | output | WAY_W | Spare row address for the second decoder |
| copy_act | output | 1 | Delayed spare-row activation pulse for a fill |
| col_ok | output | 1 | Activate-to-read delay has elapsed |

## Verification
The bench pushes a subarray to a full table and then mixes hits and misses so the victim must be the oldest use rather than the oldest fill; a design that aged entries only on fill, or picked the lowest index, would evict a recently hit row. It pins rows and thrashes around them, and fills a subarray entirely with pinned rows, where a design that let pinned entries age out would report a fill or lose the replacement. It presents a request while the controller is busy and later asks for that row, which a design that latched the stray request would report as a hit. Every command's copy and column pulses are timed against its kind, catching a swapped fast and full delay or a copy pulse after a dual.

// File: rtl/cra_pkg.sv
package cra_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_PLAIN = 2'd1,
    KIND_FILL  = 2'd2,
    KIND_DUAL  = 2'd3
  } act_kind_e;
endpackage

// File: rtl/cra_tag_store.sv
// Per-subarray tag sets: valid, pinned, tag and age per spare row.
module cra_tag_store #(
  parameter int SUBARRAYS = 4,
  parameter int WAYS      = 4,
  parameter int ROW_W     = 9,
  localparam int SA_W     = $clog2(SUBARRAYS),
  localparam int AGE_W    = $clog2(WAYS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [SA_W-1:0]                  rd_sa,
  output logic [WAYS-1:0]                  rd_valid,
  output logic [WAYS-1:0]                  rd_pin,
  output logic [WAYS-1:0][ROW_W-1:0]       rd_tag,
  output logic [WAYS-1:0][AGE_W-1:0]       rd_age,
  input  logic                             wr_en,
  input  logic [SA_W-1:0]                  wr_sa,
  input  logic [WAYS-1:0]                  wr_valid,
  input  logic [WAYS-1:0]                  wr_pin,
  input  logic [WAYS-1:0][ROW_W-1:0]       wr_tag,
  input  logic [WAYS-1:0][AGE_W-1:0]       wr_age
);

  logic [WAYS-1:0]            valid_arr [SUBARRAYS];
  logic [WAYS-1:0]            pin_arr   [SUBARRAYS];
  logic [WAYS-1:0][ROW_W-1:0] tag_arr   [SUBARRAYS];
  logic [WAYS-1:0][AGE_W-1:0] age_arr   [SUBARRAYS];

  for (genvar s = 0; s < SUBARRAYS; s++) begin : g_set
    logic                       set_we;
    logic [WAYS-1:0]            valid_q;
    logic [WAYS-1:0]            pin_q;
    logic [WAYS-1:0][ROW_W-1:0] tag_q;
    logic [WAYS-1:0][AGE_W-1:0] age_q;

    assign set_we = wr_en && (wr_sa == SA_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= '0;
        pin_q   <= '0;
        tag_q   <= '0;
        for (int w = 0; w < WAYS; w++) age_q[w] <= AGE_W'(w);
      end else if (set_we) begin
        valid_q <= wr_valid;
        pin_q   <= wr_pin;
        tag_q   <= wr_tag;
        age_q   <= wr_age;
      end
    end

    assign valid_arr[s] = valid_q;
    assign pin_arr[s]   = pin_q;
    assign tag_arr[s]   = tag_q;
    assign age_arr[s]   = age_q;
  end

  assign rd_valid = valid_arr[rd_sa];
  assign rd_pin   = pin_arr[rd_sa];
  assign rd_tag   = tag_arr[rd_sa];
  assign rd_age   = age_arr[rd_sa];

endmodule

// File: rtl/cra_lookup.sv
// Hit detection, victim choice and next set contents for one request.
module cra_lookup
  import cra_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int ROW_W  = 9,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             set_valid,
  input  logic [WAYS-1:0]             set_pin,
  input  logic [WAYS-1:0][ROW_W-1:0]  set_tag,
  input  logic [WAYS-1:0][WAY_W-1:0]  set_age,
  input  logic [ROW_W-1:0]            row,
  input  logic                        pin_req,
  output act_kind_e                   kind,
  output logic [WAY_W-1:0]            sel_way,
  output logic                        upd,
  output logic [WAYS-1:0]             nxt_valid,
  output logic [WAYS-1:0]             nxt_pin,
  output logic [WAYS-1:0][ROW_W-1:0]  nxt_tag,
  output logic [WAYS-1:0][WAY_W-1:0]  nxt_age
);

  logic             hit, free_found, cand;
  logic [WAY_W-1:0] hit_way, free_way, cand_way, cand_age, sel_age;

  always_comb begin
    hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && set_valid[w] && set_tag[w] == row) begin
        hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
    free_found = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!free_found && !set_valid[w]) begin
        free_found = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    // Oldest valid entry that is not pinned.
    cand = 1'b0;
    cand_way = '0;
    cand_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (set_valid[w] && !set_pin[w] && (!cand || set_age[w] > cand_age)) begin
        cand = 1'b1;
        cand_way = WAY_W'(w);
        cand_age = set_age[w];
      end
    end
  end

  always_comb begin
    if (hit) begin
      kind = KIND_DUAL;
      sel_way = hit_way;
    end else if (free_found) begin
      kind = KIND_FILL;
      sel_way = free_way;
    end else if (cand) begin
      kind = KIND_FILL;
      sel_way = cand_way;
    end else begin
      kind = KIND_PLAIN;
      sel_way = '0;
    end
    upd = (kind != KIND_PLAIN);
  end

  always_comb begin
    nxt_valid = set_valid;
    nxt_pin   = set_pin;
    nxt_tag   = set_tag;
    nxt_age   = set_age;
    sel_age   = set_age[sel_way];
    if (upd) begin
      nxt_valid[sel_way] = 1'b1;
      nxt_tag[sel_way]   = row;
      nxt_pin[sel_way]   = (hit && set_pin[sel_way]) || pin_req;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) != sel_way && set_age[w] < sel_age)
          nxt_age[w] = set_age[w] + 1'b1;
      end
      nxt_age[sel_way] = '0;
    end
  end

endmodule

// File: rtl/cra_timer.sv
// Activate-to-read countdown and delayed spare-row activation.
module cra_timer #(
  parameter int T_FULL = 6,
  parameter int T_FAST = 4,
  parameter int T_GAP  = 2,
  localparam int CNT_W = $clog2(T_FULL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fast,
  input  logic fill,
  output logic busy,
  output logic col_ok,
  output logic copy_act
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(T_FULL);
  localparam logic [CNT_W-1:0] FAST_C = CNT_W'(T_FAST);
  localparam logic [CNT_W-1:0] GAP_C  = CNT_W'(T_GAP);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  logic [CNT_W-1:0] rcd_q, rcd_d, gap_q, gap_d;
  logic             col_q, col_d, cpy_q, cpy_d;

  always_comb begin
    rcd_d = rcd_q;
    if (start)            rcd_d = fast ? FAST_C : FULL_C;
    else if (rcd_q != '0) rcd_d = rcd_q - ONE_C;
    gap_d = gap_q;
    if (start && fill)    gap_d = GAP_C;
    else if (gap_q != '0) gap_d = gap_q - ONE_C;
    col_d = !start && (rcd_q == ONE_C);
    cpy_d = !start && (gap_q == ONE_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcd_q <= '0;
      gap_q <= '0;
      col_q <= 1'b0;
      cpy_q <= 1'b0;
    end else begin
      rcd_q <= rcd_d;
      gap_q <= gap_d;
      col_q <= col_d;
      cpy_q <= cpy_d;
    end
  end

  assign busy     = (rcd_q != '0);
  assign col_ok   = col_q;
  assign copy_act = cpy_q;

endmodule

// File: rtl/copyrow_act_ctrl.sv
module copyrow_act_ctrl
  import cra_pkg::*;
#(
  parameter int SUBARRAYS = 4,
  parameter int WAYS      = 4,
  parameter int ROW_W     = 9,
  parameter int T_FULL    = 6,
  parameter int T_FAST    = 4,
  parameter int T_GAP     = 2,
  localparam int SA_W     = $clog2(SUBARRAYS),
  localparam int WAY_W    = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SA_W-1:0]  req_sa,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_pin,
  output logic             req_ready,
  output logic             cmd_valid,
  output logic [1:0]       cmd_kind,
  output logic [SA_W-1:0]  cmd_sa,
  output logic [ROW_W-1:0] cmd_row,
  output logic [WAY_W-1:0] cmd_copy,
  output logic             copy_act,
  output logic             col_ok
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic [WAYS-1:0]            set_valid, set_pin, nxt_valid, nxt_pin;
  logic [WAYS-1:0][ROW_W-1:0] set_tag, nxt_tag;
  logic [WAYS-1:0][WAY_W-1:0] set_age, nxt_age;
  act_kind_e                  lk_kind;
  logic [WAY_W-1:0]           lk_way;
  logic                       lk_upd, busy, accept;

  assign req_ready = rst_n_s && !busy;
  assign accept    = req_valid && req_ready;

  cra_tag_store #(.SUBARRAYS(SUBARRAYS), .WAYS(WAYS), .ROW_W(ROW_W)) u_store (
    .clk(clk), .rst_n(rst_n_s), .rd_sa(req_sa),
    .rd_valid(set_valid), .rd_pin(set_pin), .rd_tag(set_tag), .rd_age(set_age),
    .wr_en(accept && lk_upd), .wr_sa(req_sa),
    .wr_valid(nxt_valid), .wr_pin(nxt_pin), .wr_tag(nxt_tag), .wr_age(nxt_age)
  );

  cra_lookup #(.WAYS(WAYS), .ROW_W(ROW_W)) u_lookup (
    .set_valid(set_valid), .set_pin(set_pin), .set_tag(set_tag), .set_age(set_age),
    .row(req_row), .pin_req(req_pin),
    .kind(lk_kind), .sel_way(lk_way), .upd(lk_upd),
    .nxt_valid(nxt_valid), .nxt_pin(nxt_pin), .nxt_tag(nxt_tag), .nxt_age(nxt_age)
  );

  cra_timer #(.T_FULL(T_FULL), .T_FAST(T_FAST), .T_GAP(T_GAP)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .start(accept),
    .fast(lk_kind == KIND_DUAL), .fill(lk_kind == KIND_FILL),
    .busy(busy), .col_ok(col_ok), .copy_act(copy_act)
  );

  // Command register: fields load only on acceptance.
  logic             vld_q;
  act_kind_e        kind_q;
  logic [SA_W-1:0]  sa_q;
  logic [ROW_W-1:0] row_q;
  logic [WAY_W-1:0] way_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) vld_q <= 1'b0;
    else          vld_q <= accept;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      kind_q <= KIND_NONE;
      sa_q   <= '0;
      row_q  <= '0;
      way_q  <= '0;
    end else if (accept) begin
      kind_q <= lk_kind;
      sa_q   <= req_sa;
      row_q  <= req_row;
      way_q  <= lk_way;
    end
  end

  assign cmd_valid = vld_q;
  assign cmd_kind  = kind_q;
  assign cmd_sa    = sa_q;
  assign cmd_row   = row_q;
  assign cmd_copy  = way_q;

endmodule

// File: rtl/cra_ctrl_checker.sv
module cra_ctrl_checker #(
  parameter int T_FULL = 6,
  parameter int T_FAST = 4,
  parameter int T_GAP  = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       cmd_valid,
  input logic [1:0] cmd_kind,
  input logic       copy_act,
  input logic       col_ok
);

  logic [7:0] since_q;
  logic [1:0] last_kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q     <= '0;
      last_kind_q <= 2'd0;
    end else if (cmd_valid) begin
      since_q     <= 8'd1;
      last_kind_q <= cmd_kind;
    end else if (since_q != 8'hFF) begin
      since_q     <= since_q + 8'd1;
    end
  end

  p_cmd_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_busy_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  p_kind_coded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_kind != 2'd0);

  p_copy_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    copy_act |-> (last_kind_q == 2'd2 && since_q == 8'(T_GAP)));

  p_col_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    col_ok |-> (since_q == ((last_kind_q == 2'd3) ? 8'(T_FAST) : 8'(T_FULL))));

endmodule

bind copyrow_act_ctrl cra_ctrl_checker #(.T_FULL(T_FULL), .T_FAST(T_FAST), .T_GAP(T_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_valid(cmd_valid),
  .cmd_kind(cmd_kind), .copy_act(copy_act), .col_ok(col_ok)
);

// File: tb/copyrow_act_ctrl_test.sv
module copyrow_act_ctrl_test;
  localparam int SUBARRAYS = 4;
  localparam int WAYS = 4;
  localparam int ROW_W = 9;
  localparam int T_FULL = 6;
  localparam int T_FAST = 4;
  localparam int T_GAP = 2;
  localparam int SA_W = $clog2(SUBARRAYS);
  localparam int WAY_W = $clog2(WAYS);

  logic clk, rst_n, req_valid, req_pin;
  logic [SA_W-1:0] req_sa;
  logic [ROW_W-1:0] req_row;
  logic req_ready, cmd_valid, copy_act, col_ok;
  logic [1:0] cmd_kind;
  logic [SA_W-1:0] cmd_sa;
  logic [ROW_W-1:0] cmd_row;
  logic [WAY_W-1:0] cmd_copy;

  int total = 0;
  int bad = 0;

  copyrow_act_ctrl #(.SUBARRAYS(SUBARRAYS), .WAYS(WAYS), .ROW_W(ROW_W),
                     .T_FULL(T_FULL), .T_FAST(T_FAST), .T_GAP(T_GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sa(req_sa),
    .req_row(req_row), .req_pin(req_pin), .req_ready(req_ready),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_sa(cmd_sa),
    .cmd_row(cmd_row), .cmd_copy(cmd_copy), .copy_act(copy_act), .col_ok(col_ok)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference associative model of the spare-row tables.
  bit m_v [SUBARRAYS][WAYS];
  bit m_p [SUBARRAYS][WAYS];
  int m_t [SUBARRAYS][WAYS];
  int m_a [SUBARRAYS][WAYS];

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic model(input int sa, input int row, input bit pin,
                       output int kind, output int way);
    int hw = -1, fw = -1, cw = -1, ca = -1, sa_age;
    for (int w = 0; w < WAYS; w++) if (hw < 0 && m_v[sa][w] && m_t[sa][w] == row) hw = w;
    for (int w = 0; w < WAYS; w++) if (fw < 0 && !m_v[sa][w]) fw = w;
    for (int w = 0; w < WAYS; w++)
      if (m_v[sa][w] && !m_p[sa][w] && m_a[sa][w] > ca) begin cw = w; ca = m_a[sa][w]; end
    if (hw >= 0)      begin kind = 3; way = hw; end
    else if (fw >= 0) begin kind = 2; way = fw; end
    else if (cw >= 0) begin kind = 2; way = cw; end
    else              begin kind = 1; way = -1; end
    if (kind != 1) begin
      m_p[sa][way] = (hw >= 0) ? (m_p[sa][way] | pin) : pin;
      m_v[sa][way] = 1'b1;
      m_t[sa][way] = row;
      sa_age = m_a[sa][way];
      for (int w = 0; w < WAYS; w++) if (w != way && m_a[sa][w] < sa_age) m_a[sa][w]++;
      m_a[sa][way] = 0;
    end
  endtask

  task automatic do_access(input int sa, input int row, input bit pin, input bit inject,
                           input string rq, output int got_kind, output int got_way);
    int ek, ew, cpk, colk, guard, extra, early;
    model(sa, row, pin, ek, ew);
    guard = 0;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_sa = SA_W'(sa); req_row = ROW_W'(row); req_pin = pin;
    @(negedge clk);
    req_valid = 1'b0; req_pin = 1'b0;
    got_kind = int'(cmd_kind);
    got_way = int'(cmd_copy);
    check(cmd_valid == 1'b1, "R12 cmd_valid after accept", int'(cmd_valid), 1);
    check(got_kind == ek, {rq, " command kind"}, got_kind, ek);
    if (ek != 1) check(got_way == ew, {rq, " spare row"}, got_way, ew);
    check(int'(cmd_row) == row, "R12 cmd_row echo", int'(cmd_row), row);
    check(int'(cmd_sa) == sa, "R12 cmd_sa echo", int'(cmd_sa), sa);
    cpk = -1; colk = -1; extra = 0; early = 0;
    for (int k = 1; k <= 14; k++) begin
      if (inject && k == 1) begin
        req_valid = 1'b1; req_row = ROW_W'(row + 100); req_sa = SA_W'(sa);
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (cmd_valid) extra++;
      if (copy_act && cpk < 0) cpk = k;
      if (col_ok && colk < 0) colk = k;
      if (colk < 0 && req_ready) early++;
      if (colk >= 0) break;
    end
    check(extra == 0, "R6 R12 no second command while busy", extra, 0);
    check(early == 0, "R6 ready low while busy", early, 0);
    check(req_ready == 1'b1, "R6 ready with col_ok", int'(req_ready), 1);
    check(colk == ((ek == 3) ? T_FAST : T_FULL), "R5 col_ok delay", colk,
          (ek == 3) ? T_FAST : T_FULL);
    check(cpk == ((ek == 2) ? T_GAP : -1), "R4 copy_act timing", cpk,
          (ek == 2) ? T_GAP : -1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_pin = 1'b0; req_sa = '0; req_row = '0;
    for (int s = 0; s < SUBARRAYS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_v[s][w] = 0; m_p[s][w] = 0; m_t[s][w] = 0; m_a[s][w] = w;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(cmd_valid == 1'b0, "R1 cmd_valid idle", int'(cmd_valid), 0);
    check(copy_act == 1'b0, "R1 copy_act idle", int'(copy_act), 0);
    check(col_ok == 1'b0, "R1 col_ok idle", int'(col_ok), 0);
  endtask

  task automatic t_fill_hit;
    int k, w;
    do_access(0, 10, 0, 0, "R2", k, w);
    check(k == 2 && w == 0, "R2 first fill uses spare 0", w, 0);
    do_access(0, 11, 0, 0, "R2", k, w);
    check(w == 1, "R2 second fill uses spare 1", w, 1);
    do_access(0, 10, 0, 0, "R3", k, w);
    check(k == 3 && w == 0, "R3 dual on spare 0", k, 3);
  endtask

  task automatic t_lru;
    int k, w;
    do_access(0, 12, 0, 0, "R2", k, w);
    do_access(0, 13, 0, 0, "R2", k, w);
    do_access(0, 10, 0, 0, "R3", k, w);
    do_access(0, 20, 0, 0, "R7", k, w);
    check(k == 2 && w == 1, "R7 victim is least recently used", w, 1);
    do_access(0, 21, 0, 0, "R7", k, w);
    check(w == 2, "R7 next victim", w, 2);
  endtask

  task automatic t_busy;
    int k, w;
    do_access(0, 13, 0, 1, "R3", k, w);
    do_access(0, 113, 0, 0, "R6", k, w);
    check(k == 2, "R6 stray request left no entry", k, 2);
  endtask

  task automatic t_pin;
    int k, w;
    do_access(1, 5, 1, 0, "R8", k, w);
    check(k == 2 && w == 0, "R8 pin miss fills", k, 2);
    for (int r = 6; r < 14; r++) do_access(1, r, 0, 0, "R7", k, w);
    do_access(1, 5, 0, 0, "R8", k, w);
    check(k == 3 && w == 0, "R8 pinned row survives thrash", k, 3);
    do_access(1, 13, 1, 0, "R10", k, w);
    check(k == 3, "R10 pin on hit gives dual", k, 3);
    for (int r = 40; r < 48; r++) do_access(1, r, 0, 0, "R7", k, w);
    do_access(1, 13, 0, 0, "R10", k, w);
    check(k == 3, "R10 converted entry kept", k, 3);
  endtask

  task automatic t_all_pinned;
    int k, w;
    for (int r = 1; r <= WAYS; r++) do_access(2, r, 1, 0, "R8", k, w);
    do_access(2, 50, 0, 0, "R9", k, w);
    check(k == 1, "R9 plain when all pinned", k, 1);
    do_access(2, 50, 0, 0, "R9", k, w);
    check(k == 1, "R9 no allocation on plain", k, 1);
    do_access(2, 60, 1, 0, "R9", k, w);
    check(k == 1, "R9 pin request with no room", k, 1);
    do_access(2, 1, 0, 0, "R8", k, w);
    check(k == 3, "R8 pinned hit", k, 3);
  endtask

  task automatic t_indep;
    int k, w;
    do_access(3, 10, 0, 0, "R11", k, w);
    check(k == 2 && w == 0, "R11 separate table per subarray", k, 2);
  endtask

  initial begin
    t_reset();
    t_fill_hit();
    t_lru();
    t_busy();
    t_pin();
    t_all_pinned();
    t_indep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule